// File: doc/BRIEF.md
# DMA Channel Enable and Suspend Controller

This block holds the run state of a small set of DMA channels, four by default, and tells the datapath on each channel what it may do. Every channel accepts four one-cycle requests: start, stop, pause and continue. A global enable input gates all of them. Stopping is a request, not an immediate action. A stopped channel goes through a draining state and keeps its enable status at 1 until the bus burst it has in flight is over. Software polls that status and waits for 0 before it starts the channel again. A paused channel may no longer fetch from its source, but it may still deliver to its destination.

Each channel also keeps a parameter set: source address, destination address, source width code and destination width code. The block accepts writes to that set only while the channel is idle. When a start is requested, it checks that each address is aligned to its width. A bad start sets a sticky per-channel error bit, which clears only on reset. The channel FIFO and the bus master lie outside the block. They appear only as burst-active and burst-done handshake inputs and as a one-cycle flush pulse sent back to the FIFO.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset every channel is idle. Enable status, pause status, source permission, destination permission, flush and error all read 0, and every stored parameter reads 0.
- R2: A start request on an idle channel, with global enable 1 and aligned parameters, sets the enable status, the source permission and the destination permission to 1 in the cycle after the request. A start request on a channel that is already running has no effect.
- R3: A stop request on a running or paused channel moves it to draining in the next cycle. It then leaves draining at the first clock edge that sees burst-active low or burst-done high, and its enable status becomes 0 after that edge. Until then the enable status stays 1 and both permissions are 0.
- R4: Global enable at 0 acts as a stop request on every running or paused channel at once. Each channel then leaves draining according to its own burst inputs.
- R5: While global enable is 0, start requests are ignored: no channel starts and no error is set.
- R6: A pause request on a running channel sets the pause status in the next cycle and drops the source permission. The enable status and the destination permission stay 1.
- R7: A continue request on a paused channel clears the pause status and restores the source permission in the next cycle.
- R8: A parameter write, which selects its channel by number, is stored only when that channel's enable status is 0. Otherwise the stored parameters stay unchanged.
- R9: Width code w stands for 2^w bytes (0 byte, 1 half, 2 word, 3 double). An address is aligned when its w low bits are 0. A start request with a misaligned source or destination address leaves the channel idle and sets its error bit. The error bit stays 1 until reset.
- R10: A start request while the channel is draining, with global enable 1, sets the error bit. The channel finishes draining to idle and does not start.
- R11: Flush is high for exactly one cycle, on the cycle in which the enable status first reads 0 after draining.
- R12: A stop request in the same cycle as a pause request, or in the same cycle as a continue request, wins. The channel goes to draining.
- R13: A parameter write and a start request to the same idle channel in the same cycle both take effect. The alignment check uses the parameters stored before that cycle, and the new values are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| glb_en | input | 1 | Global enable level |
| start_req | input | NUM_CH | Per-channel start request pulse |
| stop_req | input | NUM_CH | Per-channel stop request pulse |
| pause_req | input | NUM_CH | Per-channel pause request pulse |
| cont_req | input | NUM_CH | Per-channel continue request pulse |
| burst_active | input | NUM_CH | Channel has a bus burst in flight |
| burst_done | input | NUM_CH | In-flight burst ends this cycle |
| prm_wr | input | 1 | Parameter write strobe |
| prm_ch | input | CH_W | Channel number for the parameter write |
| prm_src_addr | input | ADDR_W | Source address to write |
| prm_dst_addr | input | ADDR_W | Destination address to write |
| prm_src_wc | input | 2 | Source width code to write |
| prm_dst_wc | input | 2 | Destination width code to write |
| ch_src_addr | output | NUM_CH*ADDR_W | Stored source addresses, channel c at bits c*ADDR_W |
| ch_dst_addr | output | NUM_CH*ADDR_W | Stored destination addresses |
| ch_src_wc | output | NUM_CH*2 | Stored source width codes |
| ch_dst_wc | output | NUM_CH*2 | Stored destination width codes |
| en_stat | output | NUM_CH | Enable status, polled by software |
| pause_stat | output | NUM_CH | Pause status |
| src_ok | output | NUM_CH | Channel may issue new source reads |
| dst_ok | output | NUM_CH | Channel may issue destination writes |
| flush | output | NUM_CH | One-cycle FIFO flush pulse |
| err | output | NUM_CH | Sticky start error |

## Verification
Two pairs of functions can fall in the same clock edge. A stop request can meet a pause or continue request, and a parameter write can meet a start request on the same idle channel. The bench drives both members of each pair on one negative edge. For the first pair it judges that draining wins from the pause status and permissions that follow. For the second it uses parameters chosen so that only the values stored before the write would pass or fail the alignment check, then reads back the stored values. The alignment rule is swept over every width code and every value of the three low address bits, on both sides, and the expected result is computed as the address modulo the width.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int WC_W = 2;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RUN   = 2'd1,
    CH_PAUSE = 2'd2,
    CH_DRAIN = 2'd3
  } ch_state_e;
endpackage

// File: rtl/dma_align_chk.sv
module dma_align_chk
  import dma_ctl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [WC_W-1:0]   wcode,
  output logic              ok
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] low_mask;

  always_comb begin
    low_mask = (ONE << wcode) - ONE;
    ok       = ~|(addr & low_mask);
  end
endmodule

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
  import dma_ctl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic              ch_busy,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [WC_W-1:0]   src_wc_i,
  input  logic [WC_W-1:0]   dst_wc_i,
  output logic [ADDR_W-1:0] src_addr_q,
  output logic [ADDR_W-1:0] dst_addr_q,
  output logic [WC_W-1:0]   src_wc_q,
  output logic [WC_W-1:0]   dst_wc_q
);
  logic              wr_ok;
  logic [ADDR_W-1:0] src_addr_d, dst_addr_d;
  logic [WC_W-1:0]   src_wc_d, dst_wc_d;

  always_comb begin
    wr_ok      = wr_sel & ~ch_busy;
    src_addr_d = wr_ok ? src_addr_i : src_addr_q;
    dst_addr_d = wr_ok ? dst_addr_i : dst_addr_q;
    src_wc_d   = wr_ok ? src_wc_i   : src_wc_q;
    dst_wc_d   = wr_ok ? dst_wc_i   : dst_wc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr_q <= '0;
      dst_addr_q <= '0;
      src_wc_q   <= '0;
      dst_wc_q   <= '0;
    end else begin
      src_addr_q <= src_addr_d;
      dst_addr_q <= dst_addr_d;
      src_wc_q   <= src_wc_d;
      dst_wc_q   <= dst_wc_d;
    end
  end

  AST_WR_BLOCKED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ch_busy |=> ($stable(src_addr_q) && $stable(dst_addr_q) && $stable(src_wc_q) && $stable(dst_wc_q))); // R8
endmodule

// File: rtl/dma_ch_fsm.sv
module dma_ch_fsm
  import dma_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic glb_en,
  input  logic start_req,
  input  logic stop_req,
  input  logic pause_req,
  input  logic cont_req,
  input  logic burst_active,
  input  logic burst_done,
  input  logic cfg_ok,
  output logic en_stat,
  output logic pause_stat,
  output logic src_ok,
  output logic dst_ok,
  output logic flush,
  output logic err
);
  ch_state_e state_q, state_d;
  logic      flush_d, err_d, stop_any, err_set;

  always_comb begin
    state_d  = state_q;
    err_set  = 1'b0;
    flush_d  = 1'b0;
    stop_any = stop_req | ~glb_en;
    case (state_q)
      CH_IDLE: begin
        if (start_req && glb_en) begin
          if (cfg_ok) state_d = CH_RUN;
          else        err_set = 1'b1;
        end
      end
      CH_RUN: begin
        if (stop_any)       state_d = CH_DRAIN;
        else if (pause_req) state_d = CH_PAUSE;
      end
      CH_PAUSE: begin
        if (stop_any)      state_d = CH_DRAIN;
        else if (cont_req) state_d = CH_RUN;
      end
      CH_DRAIN: begin
        if (start_req && glb_en) err_set = 1'b1;
        if (!burst_active || burst_done) begin
          state_d = CH_IDLE;
          flush_d = 1'b1;
        end
      end
      default: state_d = CH_IDLE;
    endcase
    err_d = err | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      flush   <= 1'b0;
      err     <= 1'b0;
    end else begin
      state_q <= state_d;
      flush   <= flush_d;
      err     <= err_d;
    end
  end

  always_comb begin
    en_stat    = (state_q != CH_IDLE);
    pause_stat = (state_q == CH_PAUSE);
    src_ok     = (state_q == CH_RUN);
    dst_ok     = (state_q == CH_RUN) || (state_q == CH_PAUSE);
  end

  AST_DRAIN_HOLDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_DRAIN && burst_active && !burst_done) |=> en_stat); // R3
  AST_GLB_OFF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && src_ok) |=> !src_ok); // R4
  AST_NO_START_GLB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_IDLE && !glb_en) |=> (!en_stat && $stable(err))); // R5
  AST_BAD_CFG_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_IDLE && start_req && glb_en && !cfg_ok) |=> (!en_stat && err)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9
  AST_DRAIN_START_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_DRAIN && start_req && glb_en) |=> (err && !src_ok)); // R10
  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush); // R11
  AST_FLUSH_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!en_stat && $past(state_q) == CH_DRAIN)); // R11
  AST_STOP_BEATS_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ok && stop_req && pause_req) |=> (!pause_stat && en_stat)); // R12
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_ctl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     glb_en,
  input  logic [NUM_CH-1:0]        start_req,
  input  logic [NUM_CH-1:0]        stop_req,
  input  logic [NUM_CH-1:0]        pause_req,
  input  logic [NUM_CH-1:0]        cont_req,
  input  logic [NUM_CH-1:0]        burst_active,
  input  logic [NUM_CH-1:0]        burst_done,
  input  logic                     prm_wr,
  input  logic [CH_W-1:0]          prm_ch,
  input  logic [ADDR_W-1:0]        prm_src_addr,
  input  logic [ADDR_W-1:0]        prm_dst_addr,
  input  logic [WC_W-1:0]          prm_src_wc,
  input  logic [WC_W-1:0]          prm_dst_wc,
  output logic [NUM_CH*ADDR_W-1:0] ch_src_addr,
  output logic [NUM_CH*ADDR_W-1:0] ch_dst_addr,
  output logic [NUM_CH*WC_W-1:0]   ch_src_wc,
  output logic [NUM_CH*WC_W-1:0]   ch_dst_wc,
  output logic [NUM_CH-1:0]        en_stat,
  output logic [NUM_CH-1:0]        pause_stat,
  output logic [NUM_CH-1:0]        src_ok,
  output logic [NUM_CH-1:0]        dst_ok,
  output logic [NUM_CH-1:0]        flush,
  output logic [NUM_CH-1:0]        err
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              sel, src_al, dst_al;
    logic [ADDR_W-1:0] sa_q, da_q;
    logic [WC_W-1:0]   sw_q, dw_q;

    assign sel = prm_wr && (prm_ch == CH_W'(c));

    dma_ch_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .wr_sel     (sel),
      .ch_busy    (en_stat[c]),
      .src_addr_i (prm_src_addr),
      .dst_addr_i (prm_dst_addr),
      .src_wc_i   (prm_src_wc),
      .dst_wc_i   (prm_dst_wc),
      .src_addr_q (sa_q),
      .dst_addr_q (da_q),
      .src_wc_q   (sw_q),
      .dst_wc_q   (dw_q)
    );

    dma_align_chk #(.ADDR_W(ADDR_W)) u_src_al (
      .addr (sa_q), .wcode (sw_q), .ok (src_al)
    );

    dma_align_chk #(.ADDR_W(ADDR_W)) u_dst_al (
      .addr (da_q), .wcode (dw_q), .ok (dst_al)
    );

    dma_ch_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .glb_en       (glb_en),
      .start_req    (start_req[c]),
      .stop_req     (stop_req[c]),
      .pause_req    (pause_req[c]),
      .cont_req     (cont_req[c]),
      .burst_active (burst_active[c]),
      .burst_done   (burst_done[c]),
      .cfg_ok       (src_al & dst_al),
      .en_stat      (en_stat[c]),
      .pause_stat   (pause_stat[c]),
      .src_ok       (src_ok[c]),
      .dst_ok       (dst_ok[c]),
      .flush        (flush[c]),
      .err          (err[c])
    );

    assign ch_src_addr[c*ADDR_W +: ADDR_W] = sa_q;
    assign ch_dst_addr[c*ADDR_W +: ADDR_W] = da_q;
    assign ch_src_wc[c*WC_W +: WC_W]       = sw_q;
    assign ch_dst_wc[c*WC_W +: WC_W]       = dw_q;
  end

  AST_PAUSE_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((dst_ok & ~src_ok) == pause_stat)); // R6
  AST_CONT_RESUMES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pause_stat[0] && cont_req[0] && !stop_req[0] && glb_en) |=> src_ok[0]); // R7
endmodule

// File: tb/tb_dma_chan_ctl.sv
`timescale 1ns/1ps
module tb_dma_chan_ctl;
  localparam int NCH = 4;
  localparam int AW  = 32;

  logic clk, rst_n, glb_en, prm_wr;
  logic [NCH-1:0] start_req, stop_req, pause_req, cont_req, burst_active, burst_done;
  logic [1:0] prm_ch, prm_src_wc, prm_dst_wc;
  logic [AW-1:0] prm_src_addr, prm_dst_addr;
  logic [NCH*AW-1:0] ch_src_addr, ch_dst_addr;
  logic [NCH*2-1:0] ch_src_wc, ch_dst_wc;
  logic [NCH-1:0] en_stat, pause_stat, src_ok, dst_ok, flush, err;

  int n_chk = 0;
  int n_fail = 0;

  dma_chan_ctl #(.NUM_CH(NCH), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
    .start_req(start_req), .stop_req(stop_req), .pause_req(pause_req), .cont_req(cont_req),
    .burst_active(burst_active), .burst_done(burst_done),
    .prm_wr(prm_wr), .prm_ch(prm_ch), .prm_src_addr(prm_src_addr), .prm_dst_addr(prm_dst_addr),
    .prm_src_wc(prm_src_wc), .prm_dst_wc(prm_dst_wc),
    .ch_src_addr(ch_src_addr), .ch_dst_addr(ch_dst_addr), .ch_src_wc(ch_src_wc), .ch_dst_wc(ch_dst_wc),
    .en_stat(en_stat), .pause_stat(pause_stat), .src_ok(src_ok), .dst_ok(dst_ok),
    .flush(flush), .err(err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clr_in();
    start_req = '0; stop_req = '0; pause_req = '0; cont_req = '0;
    prm_wr = 1'b0; prm_ch = '0; prm_src_addr = '0; prm_dst_addr = '0;
    prm_src_wc = '0; prm_dst_wc = '0;
  endtask

  task automatic do_reset();
    clr_in();
    burst_active = '0; burst_done = '0; glb_en = 1'b1;
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic wr_prm(int c, logic [AW-1:0] sa, logic [AW-1:0] da, logic [1:0] sw, logic [1:0] dw);
    prm_wr = 1'b1; prm_ch = 2'(c); prm_src_addr = sa; prm_dst_addr = da;
    prm_src_wc = sw; prm_dst_wc = dw;
    tick();
    clr_in();
  endtask

  task automatic pulse_start(int c);
    start_req[c] = 1'b1; tick(); start_req = '0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 en", en_stat, 0);
    chk("R1 pause", pause_stat, 0);
    chk("R1 perm", {src_ok, dst_ok}, 0);
    chk("R1 flush/err", {flush, err}, 0);
    chk("R1 params", {ch_src_addr, ch_dst_addr, ch_src_wc, ch_dst_wc}, 0);

    // R2 start
    wr_prm(0, 32'h100, 32'h200, 2'd2, 2'd2);
    pulse_start(0);
    chk("R2 en", en_stat[0], 1);
    chk("R2 perm", {src_ok[0], dst_ok[0]}, 2'b11);
    // R8 write blocked while enabled
    wr_prm(0, 32'h300, 32'h400, 2'd0, 2'd0);
    chk("R8 blocked", ch_src_addr[31:0], 32'h100);
    // R2 start on running channel ignored
    pulse_start(0);
    chk("R2 restart ignored", {en_stat[0], err[0], pause_stat[0]}, 3'b100);
    // R6 pause
    pause_req[0] = 1'b1; tick(); pause_req = '0;
    chk("R6 pause", {en_stat[0], pause_stat[0], src_ok[0], dst_ok[0]}, 4'b1101);
    // R7 continue
    cont_req[0] = 1'b1; tick(); cont_req = '0;
    chk("R7 continue", {pause_stat[0], src_ok[0]}, 2'b01);
    // R3 stop waits for burst
    burst_active[0] = 1'b1;
    stop_req[0] = 1'b1; tick(); stop_req = '0;
    chk("R3 draining", {en_stat[0], src_ok[0], dst_ok[0]}, 3'b100);
    tick(); tick(); tick();
    chk("R3 still draining", {en_stat[0], flush[0]}, 2'b10);
    burst_done[0] = 1'b1; tick(); burst_done = '0; burst_active = '0;
    chk("R3 cleared", en_stat[0], 0);
    chk("R11 flush pulse", flush, 4'b0001);
    tick();
    chk("R11 flush single", flush, 0);
    // R8 write accepted when idle
    wr_prm(0, 32'h300, 32'h400, 2'd1, 2'd3);
    chk("R8 accepted", {ch_src_addr[31:0], ch_dst_addr[31:0], ch_src_wc[1:0], ch_dst_wc[1:0]},
        {32'h300, 32'h400, 2'd1, 2'd3});

    // R10 start while draining
    pulse_start(1);
    burst_active[1] = 1'b1;
    stop_req[1] = 1'b1; tick(); stop_req = '0;
    pulse_start(1);
    chk("R10 err", {err[1], en_stat[1]}, 2'b11);
    burst_active = '0; tick();
    chk("R10 idle", en_stat[1], 0);
    tick();
    chk("R10 no start", {en_stat[1], src_ok[1]}, 2'b00);

    // R4 global stop
    do_reset();
    start_req = 4'b0111; tick(); start_req = '0;
    chk("R4 running", en_stat, 4'b0111);
    burst_active[1] = 1'b1;
    glb_en = 1'b0; tick();
    chk("R4 all draining", {en_stat, src_ok}, {4'b0111, 4'b0000});
    tick();
    chk("R4 own burst", en_stat, 4'b0010);
    chk("R11 flush per ch", flush, 4'b0101);
    burst_done[1] = 1'b1; tick(); burst_done = '0; burst_active = '0;
    chk("R4 ch1 cleared", {en_stat, flush}, {4'b0000, 4'b0010});
    // R5 start ignored while global off
    start_req = 4'b1111; tick(); start_req = '0; tick();
    chk("R5 ignored", {en_stat, err}, 0);

    // R12 stop beats pause, stop beats continue
    do_reset();
    pulse_start(0);
    stop_req[0] = 1'b1; pause_req[0] = 1'b1; tick(); clr_in();
    chk("R12 stop>pause", {en_stat[0], pause_stat[0], dst_ok[0]}, 3'b100);
    tick();
    chk("R12 drained", en_stat[0], 0);
    pulse_start(1);
    pause_req[1] = 1'b1; tick(); clr_in();
    stop_req[1] = 1'b1; cont_req[1] = 1'b1; tick(); clr_in();
    chk("R12 stop>cont", {en_stat[1], pause_stat[1], src_ok[1]}, 3'b100);

    // R13 write + start same cycle
    do_reset();
    wr_prm(2, 32'h1, 32'h0, 2'd0, 2'd0);
    prm_wr = 1'b1; prm_ch = 2'd2; prm_src_addr = 32'h1; prm_src_wc = 2'd2;
    start_req[2] = 1'b1; tick(); clr_in();
    chk("R13 old cfg ok", {en_stat[2], err[2]}, 2'b10);
    chk("R13 stored", ch_src_wc[5:4], 2'd2);
    wr_prm(3, 32'h3, 32'h0, 2'd2, 2'd0);
    prm_wr = 1'b1; prm_ch = 2'd3; prm_src_addr = 32'h4; prm_src_wc = 2'd2;
    start_req[3] = 1'b1; tick(); clr_in();
    chk("R13 old cfg bad", {en_stat[3], err[3]}, 2'b01);
    chk("R13 stored addr", ch_src_addr[127:96], 32'h4);
    pulse_start(3);
    chk("R9 sticky err", {en_stat[3], err[3]}, 2'b11);

    // R9 alignment sweep
    for (int side = 0; side < 2; side++) begin
      for (int w = 0; w < 4; w++) begin
        for (int lo = 0; lo < 8; lo++) begin
          automatic logic [AW-1:0] a = 32'h1000 + 32'(lo);
          automatic bit good = ((lo % (1 << w)) == 0);
          do_reset();
          if (side == 0) wr_prm(0, a, 32'h0, 2'(w), 2'd0);
          else           wr_prm(0, 32'h0, a, 2'd0, 2'(w));
          pulse_start(0);
          chk($sformatf("R9 side%0d w%0d lo%0d", side, w, lo), {en_stat[0], err[0]}, {good, !good});
        end
      end
    end

    summary();
    $finish;
  end
endmodule